// File: doc/BRIEF.md
# I2C Slave Address Match and Acknowledge Unit

This block is the receiving front end of a two-wire serial slave. It brings SCL and SDA into the system clock domain and finds start and stop conditions. After a start it shifts in the first byte as a 7-bit address followed by a direction bit. The address is checked against a programmable station address, a reserved extension-code range and the all-zero broadcast address. When any of these hit, the block pulses an interrupt, latches the transfer direction and returns an acknowledge in the ninth clock. Any other address leaves the unit quiet until the next start or stop.

In the write direction, where the master sends to the slave, each following byte is placed on a parallel output with a one-cycle strobe and acknowledged under the same enable. If that enable is dropped, the next byte is refused and the unit ignores the rest of the transfer. The SDA output is open-drain: the block only pulls the line low or lets it go.

Top module: `iic_slave_front`

## Requirements
- R1: The first byte after a start is taken as a 7-bit address, most significant bit first, sampled on rising SCL. The address matches when it equals `own_addr_i`. A match raises `irq_o` for exactly one clock cycle.
- R2: An address whose upper four bits are 4'b1111 is an extension code. It raises one `irq_o` pulse and sets `special_o` to 1. A start clears `special_o` back to 0.
- R3: The all-zero address is a broadcast call. It raises one `irq_o` pulse and sets `special_o` to 1.
- R4: Any other address gives no `irq_o` pulse and no acknowledge. Later bytes in that transfer give no `rx_valid_o` strobe and no acknowledge.
- R5: `rw_flag_o` takes the eighth bit of an accepted address byte. 0 means slave receive and 1 means slave transmit. An address that is not accepted leaves `rw_flag_o` unchanged.
- R6: After an accepted address, the block pulls SDA low (`sda_pull_o` = 1) through the ninth SCL high phase only when `auto_ack_i` is 1. When `auto_ack_i` is 0, SDA is left released.
- R7: An acknowledge pull is released on the falling SCL edge that ends the ninth clock. `sda_pull_o` changes only while the synchronised SCL is low.
- R8: In the write direction (direction bit 0), every later byte appears on `rx_data_o`, MSB first, with a one-cycle `rx_valid_o` strobe after its eighth bit. That byte is acknowledged as in R6.
- R9: If `auto_ack_i` is 0 for a received data byte, that byte is not acknowledged. Every later byte up to the next start gives no strobe and no acknowledge.
- R10: A start or stop resets the bit count. A repeated start in the middle of a byte begins a new address byte.
- R11: After reset, `sda_pull_o`, `irq_o`, `rx_valid_o`, `rw_flag_o` and `special_o` are all 0.
- R12: In the read direction (direction bit 1), later bytes give no `rx_valid_o` strobe and no acknowledge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Serial clock line, asynchronous |
| sda_i | input | 1 | Serial data line as seen on the bus, asynchronous |
| own_addr_i | input | 7 | Station address to match |
| auto_ack_i | input | 1 | Acknowledge enable |
| sda_pull_o | output | 1 | 1 pulls SDA low, 0 releases it |
| irq_o | output | 1 | One-cycle pulse on an accepted address |
| rw_flag_o | output | 1 | Latched direction: 0 receive, 1 transmit |
| special_o | output | 1 | Last accepted address was an extension code or broadcast |
| rx_data_o | output | 8 | Last received data byte |
| rx_valid_o | output | 1 | One-cycle strobe for rx_data_o |

## Verification
Addresses are drawn from four classes: the station address, the extension range, the broadcast address and arbitrary values. This separates a true comparison from a decode of only the upper bits, and it shows whether mismatches stay silent. Each transfer has a random direction and a random acknowledge enable for each byte. That covers acknowledged and refused addresses, as well as a refusal part-way through a write burst, so a lost refusal shows up as stray strobes on the bytes that follow. Directed cases add a repeated start after three bits, a change of station address, and read-direction bursts that must stay silent.

// File: rtl/iic_slave_pkg.sv
package iic_slave_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_ADDR = 2'd1,
      PH_DATA = 2'd2,
      PH_HOLD = 2'd3
   } phase_t;
endpackage

// File: rtl/iic_line_sync.sv
module iic_line_sync #(
   parameter int WIDTH  = 2,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] async_i,
   output logic [WIDTH-1:0] sync_o
);
   generate
      if (STAGES < 2) begin : g_bad
         $error("iic_line_sync: STAGES must be at least 2");
      end
   endgenerate

   logic [WIDTH-1:0] chain [STAGES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < STAGES; i++) chain[i] <= '1;
      end else begin
         chain[0] <= async_i;
         for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
      end
   end

   assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/iic_cond_detect.sv
module iic_cond_detect (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_s,
   input  logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   logic scl_q, sda_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         scl_q <= 1'b1;
         sda_q <= 1'b1;
      end else begin
         scl_q <= scl_s;
         sda_q <= sda_s;
      end
   end

   assign scl_rise  =  scl_s & ~scl_q;
   assign scl_fall  = ~scl_s &  scl_q;
   assign start_det =  scl_s &  scl_q &  sda_q & ~sda_s;
   assign stop_det  =  scl_s &  scl_q & ~sda_q &  sda_s;
endmodule

// File: rtl/iic_slave_core.sv
module iic_slave_core
   import iic_slave_pkg::*;
#(
   parameter int ADDR_W      = 7,
   parameter int EXT_W       = 4,
   parameter bit GEN_CALL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_s,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              auto_ack,
   output logic              sda_pull,
   output logic              irq,
   output logic              rw_flag,
   output logic              special,
   output logic [ADDR_W:0]   rx_data,
   output logic              rx_valid
);
   localparam int BYTE_W  = ADDR_W + 1;
   localparam int ACK_CNT = BYTE_W + 1;
   localparam int CNT_W   = $clog2(ACK_CNT + 1);

   phase_t            phase;
   logic [CNT_W-1:0]  bitcnt;
   logic [BYTE_W-1:0] shreg;
   logic              will_ack;

   logic [BYTE_W-1:0] byte_now;
   logic [ADDR_W-1:0] addr_now;
   logic              own_hit, ext_hit, gc_hit, any_hit;
   logic              eighth_rise, ninth_rise, eighth_fall, ninth_fall;

   assign byte_now = {shreg[BYTE_W-2:0], sda_s};
   assign addr_now = byte_now[BYTE_W-1:1];

   assign own_hit = (addr_now == own_addr);
   assign ext_hit = (addr_now[ADDR_W-1 -: EXT_W] == {EXT_W{1'b1}});

   generate
      if (GEN_CALL_EN) begin : g_gc
         assign gc_hit = (addr_now == '0);
      end else begin : g_no_gc
         assign gc_hit = 1'b0;
      end
   endgenerate

   assign any_hit = own_hit | ext_hit | gc_hit;

   assign eighth_rise = scl_rise & (bitcnt == CNT_W'(BYTE_W - 1));
   assign ninth_rise  = scl_rise & (bitcnt == CNT_W'(BYTE_W));
   assign eighth_fall = scl_fall & (bitcnt == CNT_W'(BYTE_W));
   assign ninth_fall  = scl_fall & (bitcnt == CNT_W'(ACK_CNT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase    <= PH_IDLE;
         bitcnt   <= '0;
         shreg    <= '0;
         will_ack <= 1'b0;
         sda_pull <= 1'b0;
         irq      <= 1'b0;
         rw_flag  <= 1'b0;
         special  <= 1'b0;
         rx_data  <= '0;
         rx_valid <= 1'b0;
      end else begin
         irq      <= 1'b0;
         rx_valid <= 1'b0;
         if (start_det) begin
            phase    <= PH_ADDR;
            bitcnt   <= '0;
            will_ack <= 1'b0;
            sda_pull <= 1'b0;
            special  <= 1'b0;
         end else if (stop_det) begin
            phase    <= PH_IDLE;
            bitcnt   <= '0;
            will_ack <= 1'b0;
            sda_pull <= 1'b0;
         end else if (phase == PH_ADDR || phase == PH_DATA) begin
            if (scl_rise && bitcnt < CNT_W'(ACK_CNT)) begin
               bitcnt <= bitcnt + 1'b1;
               shreg  <= byte_now;
            end
            if (eighth_rise) begin
               if (phase == PH_ADDR) begin
                  if (any_hit) begin
                     irq      <= 1'b1;
                     rw_flag  <= byte_now[0];
                     special  <= ext_hit | gc_hit;
                     will_ack <= 1'b1;
                  end else begin
                     phase    <= PH_HOLD;
                     will_ack <= 1'b0;
                  end
               end else begin
                  rx_data  <= byte_now;
                  rx_valid <= 1'b1;
                  will_ack <= 1'b1;
               end
            end
            if (eighth_fall) begin
               sda_pull <= will_ack & auto_ack;
            end
            if (ninth_fall) begin
               sda_pull <= 1'b0;
               bitcnt   <= '0;
               will_ack <= 1'b0;
               if (phase == PH_ADDR)
                  phase <= (sda_pull && !rw_flag) ? PH_DATA : PH_HOLD;
               else
                  phase <= sda_pull ? PH_DATA : PH_HOLD;
            end
         end
         if (ninth_rise) begin
            bitcnt <= CNT_W'(ACK_CNT);
         end
      end
   end
endmodule

// File: rtl/iic_slave_front.sv
module iic_slave_front #(
   parameter int ADDR_W      = 7,
   parameter int SYNC_STAGES = 2,
   parameter int EXT_W       = 4,
   parameter bit GEN_CALL_EN = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   input  logic [ADDR_W-1:0] own_addr_i,
   input  logic              auto_ack_i,
   output logic              sda_pull_o,
   output logic              irq_o,
   output logic              rw_flag_o,
   output logic              special_o,
   output logic [ADDR_W:0]   rx_data_o,
   output logic              rx_valid_o
);
   generate
      if (ADDR_W != 7) begin : g_bad_addr
         $error("iic_slave_front: ADDR_W must be 7");
      end
      if (EXT_W < 1 || EXT_W > ADDR_W) begin : g_bad_ext
         $error("iic_slave_front: EXT_W out of range");
      end
   endgenerate

   logic [1:0] lines_s;
   logic       scl_s, sda_s;
   logic       scl_rise, scl_fall, start_det, stop_det;

   iic_line_sync #(.WIDTH(2), .STAGES(SYNC_STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .async_i ({scl_i, sda_i}),
      .sync_o  (lines_s)
   );

   assign scl_s = lines_s[1];
   assign sda_s = lines_s[0];

   iic_cond_detect u_cond (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_s     (scl_s),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   iic_slave_core #(
      .ADDR_W      (ADDR_W),
      .EXT_W       (EXT_W),
      .GEN_CALL_EN (GEN_CALL_EN)
   ) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .sda_s     (sda_s),
      .start_det (start_det),
      .stop_det  (stop_det),
      .own_addr  (own_addr_i),
      .auto_ack  (auto_ack_i),
      .sda_pull  (sda_pull_o),
      .irq       (irq_o),
      .rw_flag   (rw_flag_o),
      .special   (special_o),
      .rx_data   (rx_data_o),
      .rx_valid  (rx_valid_o)
   );
endmodule

// File: rtl/iic_slave_front_chk.sv
module iic_slave_front_chk (
   input logic clk,
   input logic rst_n,
   input logic scl_s,
   input logic start_det,
   input logic auto_ack_i,
   input logic sda_pull_o,
   input logic irq_o,
   input logic rx_valid_o
);
   // R1: the address interrupt lasts a single cycle
   p_irq_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |=> !irq_o);

   // R8: the data strobe lasts a single cycle
   p_valid_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rx_valid_o |=> !rx_valid_o);

   // R6: a pull only starts when the enable was set
   p_pull_needs_enable_r6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sda_pull_o) |-> $past(auto_ack_i));

   // R7: the pull only changes while SCL is low
   p_pull_edge_scl_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(sda_pull_o) |-> !scl_s);

   // R10: a start always leaves SDA released
   p_start_releases_r10: assert property (@(posedge clk) disable iff (!rst_n)
      start_det |=> !sda_pull_o);

   // R8: the address interrupt and the data strobe never coincide
   p_no_overlap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(irq_o && rx_valid_o));
endmodule

bind iic_slave_front iic_slave_front_chk u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .scl_s      (scl_s),
   .start_det  (start_det),
   .auto_ack_i (auto_ack_i),
   .sda_pull_o (sda_pull_o),
   .irq_o      (irq_o),
   .rx_valid_o (rx_valid_o)
);

// File: tb/sim_iic_slave_front.sv
module sim_iic_slave_front;
   localparam int CLK_PERIOD = 10;
   localparam int Q          = 6;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       scl_m = 1'b1;
   logic       sda_m = 1'b1;
   logic [6:0] own_addr = 7'h52;
   logic       auto_ack = 1'b1;
   logic       sda_pull, irq, rw_flag, special, rx_valid;
   logic [7:0] rx_data;
   wire        sda_bus = sda_m & ~sda_pull;

   int tests = 0;
   int fails = 0;
   int irq_cnt = 0;
   int rx_cnt = 0;
   logic [7:0] last_rx = 8'h00;
   logic exp_rw = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   iic_slave_front u0 (
      .clk        (clk),
      .rst_n      (rst_n),
      .scl_i      (scl_m),
      .sda_i      (sda_bus),
      .own_addr_i (own_addr),
      .auto_ack_i (auto_ack),
      .sda_pull_o (sda_pull),
      .irq_o      (irq),
      .rw_flag_o  (rw_flag),
      .special_o  (special),
      .rx_data_o  (rx_data),
      .rx_valid_o (rx_valid)
   );

   always @(posedge clk) begin
      if (irq) irq_cnt <= irq_cnt + 1;
      if (rx_valid) begin
         rx_cnt  <= rx_cnt + 1;
         last_rx <= rx_data;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_up();
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   endtask

   function automatic bit is_ext(input logic [6:0] a);
      return a[6:3] == 4'hF;
   endfunction

   function automatic bit is_hit(input logic [6:0] a, input logic [6:0] own);
      return (a == own) || is_ext(a) || (a == 7'h00);
   endfunction

   task automatic bus_start();
      sda_m = 1'b1; wclk(Q);
      scl_m = 1'b1; wclk(2*Q);
      sda_m = 1'b0; wclk(2*Q);
      scl_m = 1'b0; wclk(Q);
   endtask

   task automatic bus_stop();
      sda_m = 1'b0; wclk(Q);
      scl_m = 1'b1; wclk(2*Q);
      sda_m = 1'b1; wclk(2*Q);
   endtask

   task automatic send_bits(input logic [7:0] b, input int n);
      for (int i = 7; i > 7 - n; i--) begin
         sda_m = b[i]; wclk(Q);
         scl_m = 1'b1; wclk(2*Q);
         scl_m = 1'b0; wclk(Q);
      end
   endtask

   task automatic send_byte(input logic [7:0] b, output bit acked);
      send_bits(b, 8);
      sda_m = 1'b1; wclk(Q);
      scl_m = 1'b1; wclk(Q);
      acked = ~sda_bus;
      wclk(Q);
      scl_m = 1'b0; wclk(2*Q);
      chk("R7 release after ninth clock", sda_pull, 0);
   endtask

   task automatic run_txn(input logic [6:0] addr, input bit rw, input int nbytes,
                          input logic [7:0] ack_mask);
      bit hit, acked, active;
      int irq0, rx0;
      logic [7:0] d;
      hit = is_hit(addr, own_addr);
      irq0 = irq_cnt;
      bus_start();
      chk("R2 special cleared by start", special, 0);
      auto_ack = ack_mask[0];
      send_byte({addr, rw}, acked);
      chk(hit ? "R1 irq on accepted address" : "R4 no irq on mismatch", irq_cnt - irq0, hit);
      chk("R6 address acknowledge", acked, hit & ack_mask[0]);
      if (hit) exp_rw = rw;
      chk("R5 direction flag", rw_flag, exp_rw);
      chk(is_ext(addr) ? "R2 extension flag" : "R3 broadcast flag", special,
          hit & (is_ext(addr) | (addr == 7'h00)));
      active = hit & ack_mask[0] & ~rw;
      for (int k = 0; k < nbytes; k++) begin
         auto_ack = ack_mask[k+1];
         d = 8'($urandom);
         rx0 = rx_cnt;
         send_byte(d, acked);
         chk(rw ? "R12 read direction silent" : (active ? "R8 data strobe" : "R9 ignored after refusal"),
             rx_cnt - rx0, active);
         if (active) chk("R8 data value", last_rx, d);
         chk("R9 data acknowledge", acked, active & ack_mask[k+1]);
         active = active & ack_mask[k+1];
      end
      bus_stop();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_up();
   end

   initial begin
      bit acked;
      int irq0;
      void'($urandom(32'd20240611));
      wclk(3);
      chk("R11 reset pull", sda_pull, 0);
      chk("R11 reset irq", irq, 0);
      chk("R11 reset valid", rx_valid, 0);
      chk("R11 reset direction", rw_flag, 0);
      chk("R11 reset special", special, 0);
      rst_n = 1'b1;
      wclk(4);

      run_txn(7'h52, 1'b0, 3, 8'hFF);
      run_txn(7'h7A, 1'b0, 1, 8'hFF);
      run_txn(7'h00, 1'b0, 2, 8'hFF);
      run_txn(7'h13, 1'b0, 2, 8'hFF);
      run_txn(7'h52, 1'b0, 1, 8'h00);
      run_txn(7'h52, 1'b0, 4, 8'b11011);
      run_txn(7'h52, 1'b1, 2, 8'hFF);
      run_txn(7'h53, 1'b0, 1, 8'hFF);

      // R10: repeated start three bits into a byte
      irq0 = irq_cnt;
      bus_start();
      auto_ack = 1'b1;
      send_bits(8'hE5, 3);
      bus_start();
      send_byte({7'h52, 1'b0}, acked);
      chk("R10 restart mid byte irq", irq_cnt - irq0, 1);
      chk("R10 restart mid byte ack", acked, 1);
      exp_rw = 1'b0;
      bus_stop();

      own_addr = 7'h2C;
      run_txn(7'h2C, 1'b0, 1, 8'hFF);
      run_txn(7'h52, 1'b0, 1, 8'hFF);

      for (int t = 0; t < 30; t++) begin
         logic [6:0] a;
         case ($urandom % 4)
            0: a = own_addr;
            1: a = {4'hF, 3'($urandom)};
            2: a = 7'h00;
            default: a = 7'($urandom);
         endcase
         run_txn(a, 1'($urandom), int'($urandom % 4), 8'($urandom | 32'h1));
      end
      finish_up();
   end
endmodule